// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel that sits beside a free-running 16-bit timer counter. An external pin passes through a two-flop synchronizer. The block then compares each synchronized sample with the one before it to find transitions. Software sets a 3-bit control word that picks which transitions count: low-to-high, high-to-low, both, or none. On a transition it has been told to watch, the channel copies the timer value into a 16-bit capture register.

When the interrupt enable is also set, a capture raises a sticky request flag. The flag stays high until software writes 1 to bit 0 of the status register. A small read/write register port gives access to the control word, the capture value and the status flag.

The timer value comes from the `cnt_in` port by default. Setting the `INT_CNT` parameter to 1 switches the source to a free-running counter inside the block. This lets the channel be tested on its own.

Top module: `cap_channel`

## Requirements
- R1: After reset the control word reads 0, the capture register reads 0, `irq` is 0 and the status register reads 0.
- R2: When control bit 0 is set, a low-then-high sequence of synchronized pin samples loads the capture register with the timer value.
- R3: When control bit 1 is set, a high-then-low sequence of synchronized pin samples loads the capture register with the timer value.
- R4: With control bits 0 and 1 both set, the channel captures on every pin transition, in both directions.
- R5: With control bits 0 and 1 both clear, no transition changes the capture register, which keeps its last value.
- R6: A capture sets the interrupt flag only when control bit 2 is 1. With bit 2 clear, a capture leaves `irq` low.
- R7: The interrupt flag (status bit 0, and the `irq` output) stays set until a write of 1 to status bit 0. Writing 0 to that bit leaves the flag set.
- R8: Control writes keep only bits 2:0 and ignore bits 31:3, which read 0. Capture reads return the value in bits 15:0 with bits 31:16 at 0. Writes to the capture address do not change it.
- R9: Pin timing: the pin is sampled at clock edge P1 and reaches the second synchronizer flop at P2. The capture fires at P3 and stores the timer value present between P2 and P3. `irq` rises after that same edge P3.
- Register map: address 0 is the control word, address 1 is the capture value (read-only), address 2 is the status register, and any other address reads 0. `rd_data` is combinational from `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_in | input | 16 | Timer counter value to capture |
| cap_pin | input | 1 | Asynchronous capture pin |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Sticky capture interrupt request |

## Verification
The assertions check several rules on every cycle:
- a detected edge that is enabled loads exactly the timer value of that cycle;
- the capture register holds while both edge enables are clear;
- the flag never rises while its enable is clear, and never falls without a clear write;
- the upper read bits stay zero.

Only the bench scenarios can show the exact latency from pin to capture and the decoding of all eight control words in both edge directions. The same applies to the register map seen through the port, including ignored reserved bits and ignored writes to the capture address.

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int W       = 16,
  parameter int DW      = 32,
  parameter int AW      = 2,
  parameter bit INT_CNT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cnt_in,
  input  logic          cap_pin,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CAP  = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);

  logic [2:0]   ctrl_q;
  logic [W-1:0] cap_q;
  logic [W-1:0] src;
  logic         sync1_q, sync2_q, prev_q, flag_q;
  logic         rise, fall, hit;

  generate
    if (INT_CNT) begin : g_int
      logic [W-1:0] free_q;
      always_ff @(posedge clk)
        if (!rst_n) free_q <= '0;
        else        free_q <= free_q + 1'b1;
      assign src = free_q;
    end else begin : g_ext
      assign src = cnt_in;
    end
  endgenerate

  always_ff @(posedge clk)
    if (!rst_n) {sync1_q, sync2_q, prev_q} <= '0;
    else        {sync1_q, sync2_q, prev_q} <= {cap_pin, sync1_q, sync2_q};

  assign rise = sync2_q & ~prev_q & ctrl_q[0];
  assign fall = ~sync2_q & prev_q & ctrl_q[1];
  assign hit  = rise | fall;

  always_ff @(posedge clk)
    if (!rst_n)                      ctrl_q <= '0;
    else if (wr_en && addr == A_CTRL) ctrl_q <= wr_data[2:0];

  always_ff @(posedge clk)
    if (!rst_n)   cap_q <= '0;
    else if (hit) cap_q <= src;

  always_ff @(posedge clk)
    if (!rst_n)                                     flag_q <= 1'b0;
    else if (hit && ctrl_q[2])                      flag_q <= 1'b1;
    else if (wr_en && addr == A_STAT && wr_data[0]) flag_q <= 1'b0;

  always_comb
    case (addr)
      A_CTRL:  rd_data = DW'(ctrl_q);
      A_CAP:   rd_data = DW'(cap_q);
      A_STAT:  rd_data = DW'(flag_q);
      default: rd_data = '0;
    endcase

  assign irq = flag_q;
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
  parameter int W  = 16,
  parameter int DW = 32,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    ctrl,
  input logic [W-1:0]  cap,
  input logic [W-1:0]  src,
  input logic          s2,
  input logic          prev,
  input logic          irq,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data
);
  p_rise_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s2 && !prev && ctrl[0]) |=> cap == $past(src));
  p_fall_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!s2 && prev && ctrl[1]) |=> cap == $past(src));
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1:0] == 2'b00) |=> $stable(cap));
  p_no_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !ctrl[2]) |=> !irq);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == AW'(2) && wr_data[0])) |=> irq);
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:W] == '0);
endmodule

bind cap_channel cap_channel_chk #(.W(W), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .cap(cap_q), .src(src),
  .s2(sync2_q), .prev(prev_q), .irq(irq), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data)
);

// File: tb/cap_channel_tb_top.sv
`timescale 1ns/1ps
module cap_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_in = '0;
  logic        cap_pin = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int checks = 0, errors = 0;
  logic [15:0] exp_cap = '0;

  cap_channel dut_i (.clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .cap_pin(cap_pin),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  // R9: pin set before P1, value C present between P2 and P3 is the captured one
  task automatic pin_edge(input logic v, input logic [15:0] base);
    @(negedge clk); cap_pin = v; cnt_in = base;
    @(negedge clk); cnt_in = base + 16'd1;
    @(negedge clk); cnt_in = base + 16'd2;
    @(negedge clk); cnt_in = base + 16'd3;
  endtask

  initial begin
    logic [31:0] d;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 cap", d, 0);
        rd(2'd2, d); chk("R1 status", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        for (int c = 0; c < 8; c++) begin
          for (int dir = 1; dir >= 0; dir--) begin
            logic [15:0] base;
            logic hit;
            base = 16'h1000 + 16'(c * 64 + dir * 16);
            wr(2'd0, 32'(c));
            wr(2'd2, 32'h1);
            hit = dir ? c[0] : c[1];
            pin_edge(dir[0], base);
            if (hit) exp_cap = base + 16'd2;
            rd(2'd1, d);
            chk(dir ? (c[1:0] == 3 ? "R4 R2 rise" : (c[0] ? "R2 rise" : "R5 rise off"))
                    : (c[1:0] == 3 ? "R4 R3 fall" : (c[1] ? "R3 fall" : "R5 fall off")),
                d, {16'b0, exp_cap});
            chk("R9 R6 irq", {31'b0, irq}, {31'b0, hit & c[2]});
            rd(2'd2, d); chk("R6 status", d, {31'b0, hit & c[2]});
          end
        end
        wr(2'd0, 32'h5); wr(2'd2, 32'h1);
        pin_edge(1'b1, 16'h7777); exp_cap = 16'h7779;
        chk("R7 set", {31'b0, irq}, 1);
        wr(2'd2, 32'h0); chk("R7 write 0 keeps", {31'b0, irq}, 1);
        wr(2'd0, 32'h0); repeat (4) @(negedge clk);
        chk("R7 held", {31'b0, irq}, 1);
        wr(2'd2, 32'h1); chk("R7 cleared", {31'b0, irq}, 0);
        wr(2'd0, 32'hFFFF_FFF8); rd(2'd0, d); chk("R8 reserved ignored", d, 0);
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R8 ctrl bits", d, 7);
        wr(2'd1, 32'hFFFF_0000); rd(2'd1, d); chk("R8 cap write ignored", d, {16'b0, exp_cap});
        rd(2'd3, d); chk("R8 unused addr", d, 0);
        pin_edge(1'b0, 16'hFFF0); rd(2'd1, d); chk("R8 R9 cap upper zero", d, 32'h0000_FFF2);
        exp_cap = 16'hFFF2;
        pin_edge(1'b1, 16'h0100); rd(2'd1, d); chk("R4 rise with both", d, 32'h0000_0102);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule